// File: doc/BRIEF.md
# Isochronous Ping-Pong Buffer Status Tracker

This block tracks the state of two alternating isochronous transfer buffers inside an embedded USB host controller. The host fills one buffer while the controller sends the other. A buffer written during one frame goes out on the bus during the following frame. At the start of the frame after that, the buffer is marked done. The host must then read at least one 16-bit word from it within that same frame to release it.

If the host misses that read window, the done mark lapses but the buffer stays marked full. The buffer is then stuck: no later read clears it, and every write to it is refused. A stuck buffer halts all isochronous sending until a power-on reset or a software reset.

The block also raises an isochronous interrupt at every start of frame, which the host clears. A start pulse, a busy level and a buffer index stand in for the packet engine.

Top module: `iso_pingpong_status`

## Requirements
- R1: A host write strobe to an empty buffer marks it full. status_o holds buffer 0 full in bit 0, buffer 1 full in bit 1, buffer 0 done in bit 2 and buffer 1 done in bit 3.
- R2: A write strobe to a buffer already marked full changes nothing. It pulses that buffer's bit of wr_rej_o in the cycle after the strobe.
- R3: At a start of frame, a buffer that is full and neither being sent nor done starts sending. At most one buffer starts per frame. When both are eligible, the one after the last buffer started is chosen, and buffer 0 is chosen first after reset. A buffer written in the same cycle as the start of frame waits for the next one. Starting pulses proc_start_o for one cycle. proc_active_o and proc_buf_o then show the buffer for the whole frame.
- R4: At the next start of frame, the buffer that was being sent becomes done (full and done both 1).
- R5: A read strobe to a done buffer clears both its full and done marks. This includes a read in the same cycle as the closing start of frame.
- R6: A read strobe to a buffer that is empty, waiting or being sent has no effect.
- R7: If a done buffer is not read before the next start of frame, its done mark clears and its full mark stays 1. Its stuck_o bit goes to 1, and later reads do not clear it.
- R8: While any buffer is stuck, iso_halt_o is 1 and no buffer starts sending.
- R9: iso_irq_o sets at every start of frame and clears on irq_clr_i. A start of frame in the same cycle as the clear wins.
- R10: rst and soft_rst_i each return both buffers to empty and clear the stuck bits, the interrupt and the scheduling order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| sof_i | input | 1 | Start-of-frame strobe |
| host_wr_i | input | 2 | Host write strobe, one bit per buffer |
| host_rd_i | input | 2 | Host word-read strobe, one bit per buffer |
| irq_clr_i | input | 1 | Host clear of the isochronous interrupt |
| status_o | output | 4 | {done1, done0, full1, full0} |
| stuck_o | output | 2 | Buffer stuck after a missed read |
| wr_rej_o | output | 2 | Rejected-write pulse per buffer |
| iso_irq_o | output | 1 | Isochronous interrupt flag |
| proc_start_o | output | 1 | Pulse: a buffer started sending |
| proc_active_o | output | 1 | A buffer is being sent this frame |
| proc_buf_o | output | 1 | Index of the buffer being sent |
| iso_halt_o | output | 1 | Isochronous processing halted |

## Verification
The buffer count is fixed at two by the package, so the bench builds the block in its only configuration. In that configuration the bench reaches every slot transition: filling both buffers at once, a read landing on the closing start of frame, rejected writes to waiting and stuck buffers, a stuck buffer blocking its partner, and soft reset in the middle of a frame. Random frames with sparse reads drive the block into the stuck state repeatedly and release it by soft reset. A bench model built from the requirements checks every output after each edge.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;
    localparam int NBUF   = 2;
    localparam int BIDX_W = (NBUF > 1) ? $clog2(NBUF) : 1;
    localparam int STAT_W = 2 * NBUF;

    typedef enum logic [2:0] {
        SLOT_EMPTY   = 3'd0,
        SLOT_FILLED  = 3'd1,
        SLOT_SENDING = 3'd2,
        SLOT_DONE    = 3'd3,
        SLOT_STUCK   = 3'd4
    } slot_st_e;

    function automatic logic st_full(input slot_st_e s);
        return s != SLOT_EMPTY;
    endfunction

    function automatic logic st_done(input slot_st_e s);
        return s == SLOT_DONE;
    endfunction

    // first ready buffer at or after ptr, in circular order
    function automatic logic [BIDX_W-1:0] rr_pick(input logic [NBUF-1:0] ready,
                                                  input logic [BIDX_W-1:0] ptr);
        logic [BIDX_W-1:0] sel;
        sel = ptr;
        for (int k = NBUF - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(ptr) + k) % NBUF;
            if (ready[idx]) sel = BIDX_W'(idx);
        end
        return sel;
    endfunction
endpackage

// File: rtl/iso_buf_slot.sv
module iso_buf_slot
    import iso_pp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     srst,
    input  logic     sof_i,
    input  logic     wr_i,
    input  logic     rd_i,
    input  logic     start_i,
    output slot_st_e state_o,
    output logic     wr_rej_o
);
    slot_st_e state;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            state    <= SLOT_EMPTY;
            wr_rej_o <= 1'b0;
        end else begin
            wr_rej_o <= wr_i && st_full(state);
            unique case (state)
                SLOT_EMPTY:   if (wr_i) state <= SLOT_FILLED;
                SLOT_FILLED:  if (sof_i && start_i) state <= SLOT_SENDING;
                SLOT_SENDING: if (sof_i) state <= SLOT_DONE;
                SLOT_DONE: begin
                    if (rd_i)       state <= SLOT_EMPTY;
                    else if (sof_i) state <= SLOT_STUCK;
                end
                SLOT_STUCK:   state <= SLOT_STUCK;
                default:      state <= SLOT_EMPTY;
            endcase
        end
    end

    assign state_o = state;

    p_rej_needs_full_r2: assert property (@(posedge clk) disable iff (rst || srst)
        wr_rej_o |-> ($past(state) != SLOT_EMPTY && $stable(state)) || $past(sof_i) || $past(rd_i));
    p_done_after_send_r4: assert property (@(posedge clk) disable iff (rst || srst)
        (sof_i && state == SLOT_SENDING) |=> state == SLOT_DONE);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst || srst)
        (rd_i && state == SLOT_DONE) |=> state == SLOT_EMPTY);
    p_stuck_holds_r7: assert property (@(posedge clk) disable iff (rst || srst)
        state == SLOT_STUCK |=> state == SLOT_STUCK);
endmodule

// File: rtl/iso_frame_sched.sv
module iso_frame_sched
    import iso_pp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            srst,
    input  logic            sof_i,
    input  logic [NBUF-1:0] ready_i,
    input  logic            halt_i,
    output logic [NBUF-1:0] start_o,
    output logic            proc_start_o
);
    logic [BIDX_W-1:0] ptr;
    logic [BIDX_W-1:0] sel;
    logic              go;

    always_comb begin
        sel     = rr_pick(ready_i, ptr);
        go      = sof_i && !halt_i && (|ready_i);
        start_o = '0;
        if (go) start_o[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            ptr          <= '0;
            proc_start_o <= 1'b0;
        end else begin
            proc_start_o <= go;
            if (go) ptr <= BIDX_W'((int'(sel) + 1) % NBUF);
        end
    end

    p_start_onehot_r3: assert property (@(posedge clk) disable iff (rst || srst)
        $onehot0(start_o) && ((start_o & ~ready_i) == '0));
endmodule

// File: rtl/iso_irq_flag.sv
module iso_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic srst,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst || srst)  irq_o <= 1'b0;
        else if (set_i)   irq_o <= 1'b1;
        else if (clr_i)   irq_o <= 1'b0;
    end

    p_irq_on_sof_r9: assert property (@(posedge clk) disable iff (rst || srst)
        set_i |=> irq_o);
    p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst || srst)
        (clr_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/iso_pingpong_status.sv
module iso_pingpong_status
    import iso_pp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   soft_rst_i,
    input  logic                   sof_i,
    input  logic [NBUF-1:0]        host_wr_i,
    input  logic [NBUF-1:0]        host_rd_i,
    input  logic                   irq_clr_i,
    output logic [STAT_W-1:0]      status_o,
    output logic [NBUF-1:0]        stuck_o,
    output logic [NBUF-1:0]        wr_rej_o,
    output logic                   iso_irq_o,
    output logic                   proc_start_o,
    output logic                   proc_active_o,
    output logic [BIDX_W-1:0]      proc_buf_o,
    output logic                   iso_halt_o
);
    slot_st_e        st [NBUF];
    logic [NBUF-1:0] start_v;
    logic [NBUF-1:0] ready_v;
    logic [NBUF-1:0] full_v;
    logic [NBUF-1:0] done_v;
    logic [NBUF-1:0] send_v;

    for (genvar b = 0; b < NBUF; b++) begin : g_slot
        iso_buf_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .srst     (soft_rst_i),
            .sof_i    (sof_i),
            .wr_i     (host_wr_i[b]),
            .rd_i     (host_rd_i[b]),
            .start_i  (start_v[b]),
            .state_o  (st[b]),
            .wr_rej_o (wr_rej_o[b])
        );
        assign ready_v[b] = (st[b] == SLOT_FILLED);
        assign full_v[b]  = st_full(st[b]);
        assign done_v[b]  = st_done(st[b]);
        assign send_v[b]  = (st[b] == SLOT_SENDING);
        assign stuck_o[b] = (st[b] == SLOT_STUCK);
    end

    assign iso_halt_o    = |stuck_o;
    assign status_o      = {done_v, full_v};
    assign proc_active_o = |send_v;

    always_comb begin
        proc_buf_o = '0;
        for (int b = 0; b < NBUF; b++)
            if (send_v[b]) proc_buf_o = BIDX_W'(b);
    end

    iso_frame_sched u_sched (
        .clk          (clk),
        .rst          (rst),
        .srst         (soft_rst_i),
        .sof_i        (sof_i),
        .ready_i      (ready_v),
        .halt_i       (iso_halt_o),
        .start_o      (start_v),
        .proc_start_o (proc_start_o)
    );

    iso_irq_flag u_irq (
        .clk   (clk),
        .rst   (rst),
        .srst  (soft_rst_i),
        .set_i (sof_i),
        .clr_i (irq_clr_i),
        .irq_o (iso_irq_o)
    );

    p_one_sender_r3: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        $countones(send_v) <= 1);
    p_halt_blocks_r8: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        (iso_halt_o && sof_i) |=> !proc_start_o);
    p_stuck_keeps_full_r7: assert property (@(posedge clk) disable iff (rst || soft_rst_i)
        ((stuck_o & ~full_v) == '0) && ((stuck_o & done_v) == '0));
endmodule

// File: tb/iso_pingpong_status_tb.sv
`timescale 1ns/1ps
module iso_pingpong_status_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst_i = 1'b0;
    logic       sof_i = 1'b0;
    logic [1:0] host_wr_i = '0;
    logic [1:0] host_rd_i = '0;
    logic       irq_clr_i = 1'b0;
    logic [3:0] status_o;
    logic [1:0] stuck_o;
    logic [1:0] wr_rej_o;
    logic       iso_irq_o, proc_start_o, proc_active_o, iso_halt_o;
    logic [0:0] proc_buf_o;

    int checks = 0;
    int fails  = 0;

    // model: 0 empty, 1 waiting, 2 sending, 3 done, 4 stuck
    int m_st [2];
    int m_ptr;
    bit m_irq, m_pstart;
    bit [1:0] m_rej;

    always #10 clk = ~clk;

    iso_pingpong_status u_dut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .sof_i(sof_i),
        .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .irq_clr_i(irq_clr_i),
        .status_o(status_o), .stuck_o(stuck_o), .wr_rej_o(wr_rej_o),
        .iso_irq_o(iso_irq_o), .proc_start_o(proc_start_o),
        .proc_active_o(proc_active_o), .proc_buf_o(proc_buf_o),
        .iso_halt_o(iso_halt_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_st[0] = 0; m_st[1] = 0; m_ptr = 0;
        m_irq = 0; m_pstart = 0; m_rej = '0;
    endfunction

    function automatic void model_edge(bit sof, bit [1:0] wr, bit [1:0] rd, bit clr, bit srst);
        int nst [2];
        int sel;
        bit halt;
        if (srst) begin model_reset(); return; end
        halt = (m_st[0] == 4) || (m_st[1] == 4);
        sel = -1;
        if (sof && !halt) begin
            if (m_st[m_ptr] == 1) sel = m_ptr;
            else if (m_st[1 - m_ptr] == 1) sel = 1 - m_ptr;
        end
        for (int b = 0; b < 2; b++) begin
            m_rej[b] = wr[b] && (m_st[b] != 0);
            nst[b] = m_st[b];
            if (m_st[b] == 0 && wr[b]) nst[b] = 1;
            else if (m_st[b] == 3 && rd[b]) nst[b] = 0;
            else if (sof) begin
                if (m_st[b] == 2) nst[b] = 3;
                else if (m_st[b] == 3) nst[b] = 4;
                else if (m_st[b] == 1 && sel == b) nst[b] = 2;
            end
        end
        m_st[0] = nst[0]; m_st[1] = nst[1];
        m_pstart = (sel >= 0);
        if (sel >= 0) m_ptr = 1 - sel;
        if (sof) m_irq = 1; else if (clr) m_irq = 0;
    endfunction

    function automatic int exp_status();
        int s;
        s = 0;
        for (int b = 0; b < 2; b++) begin
            if (m_st[b] != 0) s |= (1 << b);
            if (m_st[b] == 3) s |= (1 << (b + 2));
        end
        return s;
    endfunction

    task automatic compare_all();
        int stk, act, bufi;
        stk = ((m_st[1] == 4) ? 2 : 0) | ((m_st[0] == 4) ? 1 : 0);
        act = (m_st[0] == 2 || m_st[1] == 2) ? 1 : 0;
        bufi = (m_st[1] == 2) ? 1 : 0;
        check("R1/R4/R5/R6 status", int'(status_o), exp_status());
        check("R7 stuck", int'(stuck_o), stk);
        check("R8 halt", int'(iso_halt_o), (stk != 0) ? 1 : 0);
        check("R2 wr_rej", int'(wr_rej_o), int'(m_rej));
        check("R9 irq", int'(iso_irq_o), int'(m_irq));
        check("R3 proc_start", int'(proc_start_o), int'(m_pstart));
        check("R3 proc_active", int'(proc_active_o), act);
        if (act != 0) check("R3 proc_buf", int'(proc_buf_o), bufi);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(bit sof, bit [1:0] wr, bit [1:0] rd, bit clr, bit srst);
        sof_i = sof; host_wr_i = wr; host_rd_i = rd; irq_clr_i = clr; soft_rst_i = srst;
        @(posedge clk);
        model_edge(sof, wr, rd, clr, srst);
        #2;
        compare_all();
        @(negedge clk);
        sof_i = 0; host_wr_i = '0; host_rd_i = '0; irq_clr_i = 0; soft_rst_i = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1-run actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd5171);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 reset status", int'(status_o), 0);
        check("R10 reset irq", int'(iso_irq_o), 0);
        check("R10 reset stuck", int'(stuck_o), 0);

        step(0, 2'b01, 0, 0, 0);
        check("R1 write fills buf0", int'(status_o), 4'b0001);
        step(0, 2'b01, 0, 0, 0);
        check("R2 rejected write", int'(wr_rej_o), 2'b01);
        step(1, 0, 0, 0, 0);
        check("R3 start buf0", int'(proc_active_o && proc_buf_o == 0 && proc_start_o), 1);
        check("R9 irq at sof", int'(iso_irq_o), 1);
        step(0, 2'b10, 0, 0, 0);
        check("R1 write fills buf1", int'(status_o), 4'b0011);
        step(0, 0, 0, 1, 0);
        check("R9 irq cleared", int'(iso_irq_o), 0);
        step(1, 0, 0, 0, 0);
        check("R4 buf0 done", int'(status_o), 4'b0111);
        check("R3 start buf1", int'(proc_buf_o), 1);
        step(0, 0, 2'b10, 0, 0);
        check("R6 read of sending buf ignored", int'(status_o), 4'b0111);
        step(0, 0, 2'b01, 0, 0);
        check("R5 read clears buf0", int'(status_o), 4'b0010);
        step(1, 0, 0, 1, 0);
        check("R4 buf1 done", int'(status_o), 4'b1010);
        check("R9 sof beats clear", int'(iso_irq_o), 1);
        step(1, 0, 0, 0, 0);
        check("R7 missed read leaves full", int'(status_o), 4'b0010);
        check("R7 stuck bit", int'(stuck_o), 2'b10);
        step(0, 0, 2'b10, 0, 0);
        check("R7 read cannot clear", int'(status_o), 4'b0010);
        step(0, 2'b01, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        check("R8 stuck blocks start", int'(proc_active_o), 0);
        step(0, 0, 0, 0, 1);
        check("R10 soft reset clears", int'(status_o), 0);
        check("R10 soft reset stuck", int'(stuck_o), 0);
        // R5 read in same cycle as closing sof
        step(0, 2'b10, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(1, 0, 2'b10, 0, 0);
        check("R5 read on sof clears", int'(status_o), 0);
        // R3 write on sof waits
        step(1, 2'b01, 0, 0, 0);
        check("R3 write on sof not started", int'(proc_active_o), 0);
        step(0, 0, 0, 0, 1);

        for (int i = 0; i < 4000; i++) begin
            bit s, c, r;
            bit [1:0] w, d;
            s = ($urandom % 6) == 0;
            w = 2'($urandom % 4) & 2'($urandom % 4);
            d = 2'($urandom % 4) & 2'($urandom % 4);
            c = ($urandom % 8) == 0;
            r = ($urandom % 150) == 0;
            step(s, w, d, c, r);
        end

        summary();
        $finish;
    end
endmodule